// File: doc/BRIEF.md
# Auxiliary DAC Update Synchronizer

This block is the register-side control for three 8-bit auxiliary voltage DACs. An upstream serial port decodes each transfer into a single-cycle write strobe with an address and a data byte. For every channel the block keeps two codes. The pending code holds the last value written. The live code is what the converter is driving. The block decides when the pending code becomes live.

There are three update policies. In the default mode a code write goes live on the same clock edge. In slave mode, code writes only load the pending registers, and a later write with update strobes moves the flagged channels. In pin-edge mode, a mask selects which channels wait for a rising edge on the transmit power-down pin. That pin is synchronized before its edge is detected. The block also holds a power-up enable and a 2-bit full-scale select for each channel. A powered-down channel still tracks code updates, but its enable stays low.

Top module: `auxdac_update_ctrl`

## Requirements
- R1: After reset all live codes are 0x00, all power enables are 0 and all full-scale selects are 00.
- R2: Outside slave mode, and for a channel whose pin-edge mask bit is clear, a write to address 0x24 (A), 0x25 (B) or 0x26 (C) loads that channel's live code on the same edge. The other channels do not change.
- R3: While slave mode is on (address 0x28, bit 7 = 1), code writes change only the pending codes. The live outputs keep their values.
- R4: A write to 0x28 with bit 7 = 1 copies the pending code to the live code for each channel whose strobe bit is 1 (bit 0 = A, bit 1 = B, bit 2 = C). The strobes are not stored, so a later write to 0x28 with strobe bits at 0 moves nothing.
- R5: Bits 4 (A), 5 (B) and 6 (C) of 0x28 form the pin-edge mask. Outside slave mode, a code write to a masked channel loads only its pending code.
- R6: Outside slave mode, a rising edge on tx_pwrdn_i copies pending to live for every masked channel, 3 clock edges after the pin rises. Holding the pin high gives exactly one transfer.
- R7: While slave mode is on, pin edges move no code.
- R8: Bits 2..0 of address 0x29 drive pwr_en_o for C, B and A, and take effect one edge after the write.
- R9: A powered-down channel still accepts code updates.
- R10: Address 0x17 sets the full-scale selects: bits 1:0 for A, 3:2 for B and 5:4 for C. The encodings are 00 = 2.5 V, 01 = 2.7 V, 10 = 3.0 V and 11 = 3.3 V.
- R11: Writes to any other address change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 8 | Register address |
| wr_data_i | input | 8 | Register write data |
| tx_pwrdn_i | input | 1 | Asynchronous transmit power-down pin |
| code_o | output | 24 | Live codes; A in bits 7:0, B in 15:8, C in 23:16 |
| pwr_en_o | output | 3 | Power-up enable per channel (bit 0 = A) |
| fs_sel_o | output | 6 | Full-scale select per channel (A in bits 1:0) |

## Verification
The bench uses the default parameters: three channels of eight bits, with an 8-bit address and data. This size lets it cover every case in full:
- all eight strobe patterns and all eight pin-edge masks, each against fresh pending values
- all eight power patterns and all 64 full-scale combinations
- a write of all ones to every undecoded address

For each of these, the expected codes are computed from a small register model in the bench.

// File: rtl/auxdac_pkg.sv
package auxdac_pkg;
  localparam int unsigned NCH_DEF    = 3;
  localparam int unsigned CODE_W_DEF = 8;
  localparam int unsigned FS_W_DEF   = 2;
  localparam int unsigned ADDR_W_DEF = 8;
  localparam int unsigned DATA_W_DEF = 8;

  localparam logic [7:0] ADDR_FS    = 8'h17;
  localparam logic [7:0] ADDR_CODE0 = 8'h24;
  localparam logic [7:0] ADDR_SYNC  = 8'h28;
  localparam logic [7:0] ADDR_PWR   = 8'h29;

  localparam int unsigned SLAVE_BIT = 7;
  localparam int unsigned MASK_LSB  = 4;

  typedef enum logic [1:0] {
    FS_2V5 = 2'b00,
    FS_2V7 = 2'b01,
    FS_3V0 = 2'b10,
    FS_3V3 = 2'b11
  } fs_sel_e;
endpackage

// File: rtl/auxdac_pin_edge.sv
module auxdac_pin_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  // one pulse per edge
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/auxdac_chan.sv
module auxdac_chan #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_wr_i,
  input  logic              imm_i,
  input  logic              xfer_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] live_o
);
  logic [CODE_W-1:0] pend_q, live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      live_q <= '0;
    end else begin
      if (code_wr_i) pend_q <= code_i;
      if (imm_i)       live_q <= code_i;
      else if (xfer_i) live_q <= pend_q;
    end
  end

  assign live_o = live_q;

  assert_pend_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_wr_i |=> pend_q == $past(code_i));
  assert_live_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!imm_i && !xfer_i) |=> $stable(live_q));
  assert_strobe_xfer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i && !imm_i) |=> live_q == $past(pend_q));
endmodule

// File: rtl/auxdac_cfg_regs.sv
module auxdac_cfg_regs
  import auxdac_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned FS_W   = FS_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 pin_rise_i,
  output logic [NCH-1:0]       code_wr_o,
  output logic [NCH-1:0]       imm_o,
  output logic [NCH-1:0]       xfer_o,
  output logic                 slave_o,
  output logic [NCH-1:0]       pwr_en_o,
  output logic [NCH*FS_W-1:0]  fs_sel_o
);
  localparam int unsigned FS_BITS = NCH * FS_W;

  logic               slave_q;
  logic [NCH-1:0]     mask_q, pwr_q;
  logic [FS_BITS-1:0] fs_q;
  logic               wr_sync, wr_pwr, wr_fs, strobe_wr;

  assign wr_sync   = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_SYNC));
  assign wr_pwr    = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_PWR));
  assign wr_fs     = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_FS));
  assign strobe_wr = wr_sync && wr_data_i[SLAVE_BIT];

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    assign code_wr_o[c] = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CODE0 + c));
    assign imm_o[c]     = code_wr_o[c] && !slave_q && !mask_q[c];
    // strobe has priority path; pin edge gated off in slave mode
    assign xfer_o[c]    = (strobe_wr && wr_data_i[c]) ||
                          (!slave_q && mask_q[c] && pin_rise_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slave_q <= 1'b0;
      mask_q  <= '0;
      pwr_q   <= '0;
      fs_q    <= '0;
    end else begin
      if (wr_sync) begin
        slave_q <= wr_data_i[SLAVE_BIT];
        mask_q  <= wr_data_i[MASK_LSB +: NCH];
      end
      if (wr_pwr) pwr_q <= wr_data_i[NCH-1:0];
      if (wr_fs)  fs_q  <= wr_data_i[FS_BITS-1:0];
    end
  end

  assign slave_o  = slave_q;
  assign pwr_en_o = pwr_q;
  assign fs_sel_o = fs_q;

  assert_pwr_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pwr |=> pwr_en_o == $past(wr_data_i[NCH-1:0]));
  assert_fs_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fs |=> fs_sel_o == $past(wr_data_i[FS_BITS-1:0]));
  assert_cfg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pwr_en_o) && $stable(fs_sel_o));
endmodule

// File: rtl/auxdac_update_ctrl.sv
module auxdac_update_ctrl
  import auxdac_pkg::*;
#(
  parameter int unsigned NCH    = NCH_DEF,
  parameter int unsigned CODE_W = CODE_W_DEF,
  parameter int unsigned FS_W   = FS_W_DEF,
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  tx_pwrdn_i,
  output logic [NCH*CODE_W-1:0] code_o,
  output logic [NCH-1:0]        pwr_en_o,
  output logic [NCH*FS_W-1:0]   fs_sel_o
);
  logic           pin_rise;
  logic           slave_w;
  logic [NCH-1:0] code_wr, imm, xfer;

  auxdac_pin_edge #(.STAGES(SYNC_STAGES)) u_pin_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (tx_pwrdn_i),
    .rise_o (pin_rise)
  );

  auxdac_cfg_regs #(
    .NCH(NCH), .FS_W(FS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .pin_rise_i (pin_rise),
    .code_wr_o  (code_wr),
    .imm_o      (imm),
    .xfer_o     (xfer),
    .slave_o    (slave_w),
    .pwr_en_o   (pwr_en_o),
    .fs_sel_o   (fs_sel_o)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    auxdac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_wr_i (code_wr[c]),
      .imm_i     (imm[c]),
      .xfer_i    (xfer[c]),
      .code_i    (wr_data_i[CODE_W-1:0]),
      .live_o    (code_o[c*CODE_W +: CODE_W])
    );
  end

  assert_slave_pin_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_w && !wr_en_i) |=> $stable(code_o));
  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !pin_rise) |=> $stable(code_o));
endmodule

// File: tb/test_auxdac_update_ctrl.sv
module test_auxdac_update_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        tx_pwrdn_i = 1'b0;
  logic [23:0] code_o;
  logic [2:0]  pwr_en_o;
  logic [5:0]  fs_sel_o;

  always #5 clk_i = ~clk_i;

  auxdac_update_ctrl i_auxdac_update_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .tx_pwrdn_i(tx_pwrdn_i), .code_o(code_o),
    .pwr_en_o(pwr_en_o), .fs_sel_o(fs_sel_o)
  );

  int vecs = 0, errs = 0;
  logic [7:0] m_pend[3], m_live[3];
  logic       m_slave = 1'b0;
  logic [2:0] m_mask = '0, m_pwr = '0;
  logic [5:0] m_fs = '0;
  bit         done = 1'b0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < 3; c++) chk(req, 32'(code_o[c*8 +: 8]), 32'(m_live[c]));
    chk(req, 32'(pwr_en_o), 32'(m_pwr));
    chk(req, 32'(fs_sel_o), 32'(m_fs));
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    if (a >= 8'h24 && a <= 8'h26) begin
      m_pend[a-8'h24] = d;
      if (!m_slave && !m_mask[a-8'h24]) m_live[a-8'h24] = d;
    end else if (a == 8'h28) begin
      m_slave = d[7]; m_mask = d[6:4];
      if (d[7]) for (int c = 0; c < 3; c++) if (d[c]) m_live[c] = m_pend[c];
    end else if (a == 8'h29) m_pwr = d[2:0];
    else if (a == 8'h17) m_fs = d[5:0];
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pin_high();
    @(negedge clk_i);
    tx_pwrdn_i = 1'b1;
    repeat (3) @(posedge clk_i);
    if (!m_slave) for (int c = 0; c < 3; c++) if (m_mask[c]) m_live[c] = m_pend[c];
    @(negedge clk_i);
  endtask

  task automatic pin_low();
    @(negedge clk_i);
    tx_pwrdn_i = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    for (int c = 0; c < 3; c++) begin m_pend[c] = '0; m_live[c] = '0; end
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    chk_all("R1");

    // immediate mode while powered down
    for (int c = 0; c < 3; c++)
      for (int v = 0; v < 256; v += 15) begin
        wr(8'(8'h24 + c), 8'(v + c));
        chk_all("R2/R9");
      end

    for (int p = 0; p < 8; p++) begin wr(8'h29, 8'(p)); chk_all("R8"); end
    for (int f = 0; f < 64; f++) begin wr(8'h17, 8'(f)); chk_all("R10"); end

    // slave mode strobes
    wr(8'h28, 8'h80);
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 3; c++) wr(8'(8'h24 + c), 8'(8'h31 * s + 8'h10 * c + 1));
      chk_all("R3");
      wr(8'h28, 8'(8'h80 | s));
      chk_all("R4");
      wr(8'h28, 8'h80);
      chk_all("R4");
    end
    for (int c = 0; c < 3; c++) wr(8'(8'h24 + c), 8'(8'hA0 + c));
    wr(8'h28, 8'hF0);  // slave with mask set
    pin_high();
    chk_all("R7");
    pin_low();
    chk_all("R7");

    // pin-edge mode
    for (int m = 0; m < 8; m++) begin
      wr(8'h28, 8'(m << 4));
      for (int c = 0; c < 3; c++) wr(8'(8'h24 + c), 8'(8'h17 * m + 8'h40 * c + 3));
      chk_all("R5");
      pin_high();
      chk_all("R6");
      for (int c = 0; c < 3; c++) wr(8'(8'h24 + c), 8'(8'hC5 - 8'h11 * m - c));
      repeat (4) @(negedge clk_i);
      chk_all("R6");
      pin_low();
      chk_all("R6");
    end

    wr(8'h28, 8'h00);
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h17 || a == 8'h24 || a == 8'h25 || a == 8'h26 ||
          a == 8'h28 || a == 8'h29) continue;
      wr(8'(a), 8'hFF);
      chk_all("R11");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      errs++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule